// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs serial flash transactions one command word at a time over a four-wire, mode-3 serial link. Software first places an address in the address register and, for a write, up to four payload bytes in the data register. It then writes a command word. The sequencer sends the bytes for each enabled phase in turn: the opcode, then 0 to 3 address bytes, then 0 to 15 zero-filled dummy bytes, then 0 to 4 data bytes moving in the chosen direction. A pending flag stays up in the status register while this runs.

A hold flag in the command word keeps the chip select low after the command ends. A long flash transaction can therefore be split over several commands: a command that starts while the select is still held sends no opcode, and a command with the hold flag clear releases the select when it finishes. A second command written while one is still running is refused, and a sticky error flag records the refusal.

The serial clock shape comes from a timing register. It sets the bit period and the positions of the falling and rising edges inside that period, all counted in controller clock cycles.

Top module: `sf_cmd_seq`

## Requirements
- R1: Registers are selected by word index on `busAddr`: 0 command, 1 address, 2 data, 3 status, 4 timing. Reads are combinational. After reset `csN` and `sck` are 1, status reads 0, and timing reads 0x0000_0204.
- R2: Command word fields: opcode in bits 7:0, write flag in bit 8, data byte count in bits 11:9, hold flag in bit 15, dummy byte count in bits 19:16, address byte count in bits 22:20.
- R3: If `csN` is high when a command is accepted, the opcode byte goes out first. If `csN` is still held low from an earlier command, the opcode phase is skipped.
- R4: An address byte count of 1 to 3 sends that many low bytes of the address register, most significant of them first. A count above 3 acts as 3.
- R5: The dummy phase sends the given number of bytes (0 to 15), each 0x00.
- R6: A write sends data-register bits 7:0 first, then 15:8, and so on. A data byte count above 4 acts as 4.
- R7: A read drives 0x00 on `mosi` during the data phase. The first received byte lands in data bits 7:0, the next in 15:8, and so on. The bytes not received read as zero, and all of this is in place before the pending bit clears.
- R8: Status bit 22 (pending) reads 1 from the cycle after a command is accepted until its last byte has completed.
- R9: When a command ends, `csN` stays low if its hold flag is set and goes high if it is clear. A command with the hold flag clear and nothing to send closes a held sequence without toggling `sck`.
- R10: Mode 3: `sck` idles high, `mosi` changes only on falling edges of `sck`, `miso` is sampled on rising edges, and bytes go most significant bit first.
- R11: Timing register: bit period P in bits 3:0, falling-edge position F in bits 15:12, rising-edge position R in bits 11:8, all in clock cycles, for F < R < P. Consecutive rising edges inside one byte are P cycles apart.
- R12: A command write while pending is 1 is dropped. The running command completes unchanged, and status bit 29 (error) becomes 1.
- R13: The error bit stays at 1 until status is written with bit 29 set. A status write with bit 29 clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock, idles high |
| csN | output | 1 | Active-low flash select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The assertions assume the timing register always satisfies F < R < P. Under that assumption the serial clock is back high before each byte ends, so `sck` is high whenever the block is idle or deselected. They also assume software leaves the address and data registers alone while a command is pending. The stimulus rewrites timing only between commands and always with legal edge positions, and it touches the address and data registers only after polling pending to zero. The one exception is a deliberate command write during a busy command, used to provoke the error flag.

// File: rtl/sf_seq_pkg.sv
package sf_seq_pkg;
  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] REG_CMD    = 3'd0;
  localparam logic [REG_IDX_W-1:0] REG_ADDR   = 3'd1;
  localparam logic [REG_IDX_W-1:0] REG_DATA   = 3'd2;
  localparam logic [REG_IDX_W-1:0] REG_STATUS = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_TIMING = 3'd4;
  localparam int PEND_BIT = 22;
  localparam int ERR_BIT  = 29;
  localparam logic [15:0] TIMING_RESET = 16'h0204;

  typedef struct packed {
    logic       startByte;
    logic [7:0] txByte;
  } seq_strobe_t;
endpackage

// File: rtl/sf_seq_dp.sv
module sf_seq_dp
  import sf_seq_pkg::*;
#(
  parameter int TICK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobes,
  input  logic [TICK_W-1:0] period,
  input  logic [TICK_W-1:0] fallPos,
  input  logic [TICK_W-1:0] risePos,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              byteDone,
  output logic [7:0]        rxByte
);
  logic [TICK_W-1:0] tick;
  logic [2:0]        bitCnt;
  logic              active;
  logic [7:0]        shiftReg;
  logic [TICK_W-1:0] lastTick;

  assign lastTick = period - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck      <= 1'b1;
      mosi     <= 1'b0;
      byteDone <= 1'b0;
      rxByte   <= '0;
      tick     <= '0;
      bitCnt   <= '0;
      active   <= 1'b0;
      shiftReg <= '0;
    end else begin
      byteDone <= 1'b0;
      if (strobes.startByte) begin
        shiftReg <= strobes.txByte;
        tick     <= '0;
        bitCnt   <= '0;
        active   <= 1'b1;
      end else if (active) begin
        if (tick == fallPos) begin
          sck  <= 1'b0;
          mosi <= shiftReg[7];
        end
        if (tick == risePos) begin
          sck    <= 1'b1;
          rxByte <= {rxByte[6:0], miso};
        end
        if (tick == lastTick) begin
          tick     <= '0;
          shiftReg <= {shiftReg[6:0], 1'b0};
          bitCnt   <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            active   <= 1'b0;
            byteDone <= 1'b1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sf_seq_ctrl.sv
module sf_seq_ctrl
  import sf_seq_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int MAX_ADDR   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [REG_IDX_W-1:0] busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 byteDone,
  input  logic [7:0]           rxByte,
  output seq_strobe_t          strobes,
  output logic [15:0]          timingReg,
  output logic                 pendingFlag,
  output logic                 errorFlag,
  output logic                 csN
);
  localparam int DATA_W = 8 * DATA_BYTES;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} seq_state_t;

  seq_state_t        state;
  logic [31:0]       cmdWord;
  logic [31:0]       addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              opcLeft;
  logic [1:0]        adrLeft;
  logic [3:0]        dumLeft;
  logic [2:0]        datLeft;
  logic [1:0]        datIdx;
  logic              curData;
  logic              dirWrite;
  logic              holdCs;
  logic              cmdWr;
  logic              errSet;
  logic              errClr;
  logic              finishing;
  logic [1:0]        adrLenIn;
  logic [2:0]        datLenIn;

  assign cmdWr  = busWr && (busAddr == REG_CMD);
  assign errSet = cmdWr && pendingFlag;
  assign errClr = busWr && (busAddr == REG_STATUS) && busWdata[ERR_BIT];
  assign adrLenIn = (busWdata[22:20] > 3'(MAX_ADDR)) ? 2'(MAX_ADDR) : busWdata[21:20];
  assign datLenIn = (busWdata[11:9] > 3'(DATA_BYTES)) ? 3'(DATA_BYTES) : busWdata[11:9];
  assign finishing = (state == ST_LOAD) && !opcLeft && (adrLeft == 2'd0)
                     && (dumLeft == 4'd0) && (datLeft == 3'd0);

  always_comb begin
    strobes = '0;
    if (state == ST_LOAD && !finishing) begin
      strobes.startByte = 1'b1;
      if (opcLeft)
        strobes.txByte = cmdWord[7:0];
      else if (adrLeft != 2'd0)
        strobes.txByte = addrReg[{adrLeft - 2'd1, 3'b000} +: 8];
      else if (dumLeft != 4'd0)
        strobes.txByte = 8'h00;
      else
        strobes.txByte = dirWrite ? dataReg[{datIdx, 3'b000} +: 8] : 8'h00;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_CMD:    busRdata = cmdWord;
      REG_ADDR:   busRdata = addrReg;
      REG_DATA:   busRdata = 32'(dataReg);
      REG_STATUS: begin
        busRdata[PEND_BIT] = pendingFlag;
        busRdata[ERR_BIT]  = errorFlag;
      end
      REG_TIMING: busRdata = {16'h0000, timingReg};
      default:    busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cmdWord     <= '0;
      addrReg     <= '0;
      dataReg     <= '0;
      timingReg   <= TIMING_RESET;
      pendingFlag <= 1'b0;
      errorFlag   <= 1'b0;
      csN         <= 1'b1;
      opcLeft     <= 1'b0;
      adrLeft     <= '0;
      dumLeft     <= '0;
      datLeft     <= '0;
      datIdx      <= '0;
      curData     <= 1'b0;
      dirWrite    <= 1'b0;
      holdCs      <= 1'b0;
    end else begin
      errorFlag <= errSet | (errorFlag & ~errClr);
      if (busWr && busAddr == REG_ADDR)   addrReg   <= busWdata;
      if (busWr && busAddr == REG_DATA)   dataReg   <= busWdata[DATA_W-1:0];
      if (busWr && busAddr == REG_TIMING) timingReg <= busWdata[15:0];
      if (cmdWr && !pendingFlag) begin
        cmdWord     <= busWdata;
        pendingFlag <= 1'b1;
        csN         <= 1'b0;
        opcLeft     <= csN;
        adrLeft     <= adrLenIn;
        dumLeft     <= busWdata[19:16];
        datLeft     <= datLenIn;
        datIdx      <= '0;
        dirWrite    <= busWdata[8];
        holdCs      <= busWdata[15];
        if (!busWdata[8]) dataReg <= '0;
        state       <= ST_LOAD;
      end
      case (state)
        ST_LOAD: begin
          if (finishing) begin
            pendingFlag <= 1'b0;
            csN         <= !holdCs;
            state       <= ST_IDLE;
          end else begin
            curData <= 1'b0;
            if (opcLeft)                opcLeft <= 1'b0;
            else if (adrLeft != 2'd0)   adrLeft <= adrLeft - 2'd1;
            else if (dumLeft != 4'd0)   dumLeft <= dumLeft - 4'd1;
            else begin
              datLeft <= datLeft - 3'd1;
              curData <= 1'b1;
            end
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (byteDone) begin
            if (curData) begin
              if (!dirWrite) dataReg[{datIdx, 3'b000} +: 8] <= rxByte;
              datIdx <= datIdx + 2'd1;
            end
            state <= ST_LOAD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sf_cmd_seq.sv
module sf_cmd_seq
  import sf_seq_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int MAX_ADDR   = 3,
  parameter int TICK_W     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sck,
  output logic        csN,
  output logic        mosi,
  input  logic        miso
);
  seq_strobe_t strobes;
  logic        byteDone;
  logic [7:0]  rxByte;
  logic [15:0] timingReg;
  logic        pendingFlag;
  logic        errorFlag;

  sf_seq_ctrl #(.DATA_BYTES(DATA_BYTES), .MAX_ADDR(MAX_ADDR)) ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .byteDone(byteDone),
    .rxByte(rxByte), .strobes(strobes), .timingReg(timingReg),
    .pendingFlag(pendingFlag), .errorFlag(errorFlag), .csN(csN)
  );

  sf_seq_dp #(.TICK_W(TICK_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .period(timingReg[TICK_W-1:0]), .fallPos(timingReg[12 +: TICK_W]),
    .risePos(timingReg[8 +: TICK_W]), .miso(miso), .sck(sck),
    .mosi(mosi), .byteDone(byteDone), .rxByte(rxByte)
  );
endmodule

// File: rtl/sf_seq_chk.sv
module sf_seq_chk
  import sf_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [2:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        sck,
  input logic        csN,
  input logic        mosi,
  input logic        pendingFlag,
  input logic        errorFlag,
  input seq_strobe_t strobes
);
  AST_SCK_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sck); // R10
  AST_SCK_HIGH_NOT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    !pendingFlag |-> sck); // R9
  AST_MOSI_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)); // R10
  AST_BUSY_CMD_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    (pendingFlag && busWr && busAddr == REG_CMD) |=> errorFlag); // R12
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errorFlag && !(busWr && busAddr == REG_STATUS && busWdata[ERR_BIT])) |=> errorFlag); // R13
  AST_BYTE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startByte |-> (pendingFlag && !csN)); // R8
endmodule

bind sf_cmd_seq sf_seq_chk chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .sck(sck), .csN(csN), .mosi(mosi),
  .pendingFlag(pendingFlag), .errorFlag(errorFlag), .strobes(strobes)
);

// File: tb/sf_cmd_seq_test.sv
`timescale 1ns/1ps
module sf_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, csN, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int fails = 0;
  int periodBad = 0;
  int expPeriod = 4;
  logic [7:0] expQ[$];

  int modelBits = 0;
  int modelIdx = 0;
  logic [7:0] rxShift = '0;
  time lastRise = 0;

  bit curHeld = 0;
  int heldIdx = 0;
  bit runHold, runRead;
  int runDlen, runBase;

  sf_cmd_seq uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'hC3 ^ 8'(i * 37);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash model and monitor: pops expected MOSI bytes
  always @(negedge sck) if (!csN) miso = pat(modelIdx)[7 - modelBits];

  always @(posedge sck or posedge csN) begin
    if (csN) begin
      modelBits = 0;
      modelIdx = 0;
    end else begin
      if (modelBits != 0 && ($time - lastRise) != time'(expPeriod * 4)) periodBad++;
      lastRise = $time;
      rxShift = {rxShift[6:0], mosi};
      modelBits++;
      if (modelBits == 8) begin
        modelBits = 0;
        modelIdx++;
        if (expQ.size() == 0) check(0, "R3 R4 R5 R6 R10 unexpected byte", 32'(rxShift), 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(rxShift == e, "R3 R4 R5 R6 R10 mosi byte", 32'(rxShift), 32'(e));
        end
      end
    end
  end

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  function automatic logic [31:0] mkCmd(logic [7:0] opc, bit wr, int dlen, bit hold, int dum, int alen);
    return 32'(opc) | (32'(wr) << 8) | (32'(dlen) << 9) | (32'(hold) << 15)
         | (32'(dum) << 16) | (32'(alen) << 20);
  endfunction

  task automatic startCmd(logic [7:0] opc, bit wr, int dlen, bit hold, int dum, int alen,
                          logic [31:0] addr, logic [31:0] data);
    logic [31:0] st;
    int al, dl, n;
    al = (alen > 3) ? 3 : alen;
    dl = (dlen > 4) ? 4 : dlen;
    runBase = curHeld ? heldIdx : 0;
    n = 0;
    if (!curHeld) begin expQ.push_back(opc); n++; end
    for (int k = al - 1; k >= 0; k--) begin expQ.push_back(addr[8*k +: 8]); n++; end
    for (int k = 0; k < dum; k++) begin expQ.push_back(8'h00); n++; end
    runBase += n;
    for (int k = 0; k < dl; k++) expQ.push_back(wr ? data[8*k +: 8] : 8'h00);
    heldIdx = hold ? runBase + dl : 0;
    runHold = hold; runRead = !wr; runDlen = dl;
    busWrite(3'd1, addr);
    busWrite(3'd2, data);
    busWrite(3'd0, mkCmd(opc, wr, dlen, hold, dum, alen));
    busRead(3'd3, st);
    check(st[22] == 1'b1, "R8 pending after command", st, 32'h0040_0000);
  endtask

  task automatic finishCmd();
    logic [31:0] st, d, e;
    do begin
      @(negedge clk);
      busRead(3'd3, st);
    end while (st[22]);
    check(expQ.size() == 0, "R3 R4 R5 R6 all bytes sent", 32'(expQ.size()), 0);
    check(csN == !runHold, "R9 select after command", 32'(csN), 32'(!runHold));
    check(sck == 1'b1, "R10 clock idle high", 32'(sck), 1);
    check(periodBad == 0, "R11 bit period", 32'(periodBad), 0);
    if (runRead) begin
      e = '0;
      for (int k = 0; k < runDlen; k++) e[8*k +: 8] = pat(runBase + k);
      busRead(3'd2, d);
      check(d == e, "R7 read data", d, e);
    end
    curHeld = runHold;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRead(3'd3, v);
    check(v == 0, "R1 status at reset", v, 0);
    busRead(3'd4, v);
    check(v == 32'h0204, "R1 timing at reset", v, 32'h0204);
    check(csN && sck, "R1 R10 pins at reset", {csN, sck}, 2'b11);

    // R3 opcode only
    startCmd(8'h06, 1'b1, 0, 1'b0, 0, 0, 0, 0); finishCmd();
    // R4 R6 write with 3-byte address
    startCmd(8'h02, 1'b1, 3, 1'b0, 0, 3, 32'h0012_3456, 32'h00CC_BBAA); finishCmd();
    // R5 R7 R9 held read, continued read, close
    startCmd(8'h0B, 1'b0, 4, 1'b1, 1, 3, 32'h00AB_CDEF, 0); finishCmd();
    startCmd(8'h0B, 1'b0, 2, 1'b1, 0, 0, 0, 32'hFFFF_FFFF); finishCmd();
    startCmd(8'h00, 1'b1, 0, 1'b0, 0, 0, 0, 0); finishCmd();
    // R4 R6 clamps: address count 5 acts as 3, data count 6 acts as 4
    startCmd(8'h32, 1'b1, 6, 1'b0, 2, 5, 32'h7788_99AA, 32'h4433_2211); finishCmd();
    startCmd(8'h05, 1'b1, 0, 1'b0, 0, 2, 32'h0000_BEEF, 0); finishCmd();
    // R11 new timing: P=6 R=4 F=1
    busWrite(3'd4, 32'h0000_1406);
    expPeriod = 6;
    startCmd(8'h03, 1'b0, 1, 1'b0, 0, 1, 32'h0000_0042, 0); finishCmd();
    // R12 busy command write, R13 sticky error
    startCmd(8'h0B, 1'b0, 2, 1'b0, 15, 3, 32'h0001_0203, 0);
    busWrite(3'd0, mkCmd(8'hAA, 1'b1, 4, 1'b1, 0, 0));
    busRead(3'd3, v);
    check(v[29] == 1'b1, "R12 error on busy command", v, 32'h2040_0000);
    finishCmd();
    busWrite(3'd3, 32'h0000_0000);
    busRead(3'd3, v);
    check(v[29] == 1'b1, "R13 error sticky", v, 32'h2000_0000);
    busWrite(3'd3, 32'h2000_0000);
    busRead(3'd3, v);
    check(v == 0, "R13 error cleared", v, 0);
    busRead(3'd0, v);
    check(v[7:0] == 8'h0B, "R2 R12 busy command not captured", v, 32'h0000_000B);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule